// File: doc/BRIEF.md
# Programmed-I/O Disk Bus Cycle Sequencer

This block performs one programmed-I/O access on a 16-bit parallel disk-drive bus for each request it receives. A request carries a 4-bit device register index, a direction flag and 16 bits of write data. The sequencer drives the register index and an active-low chip select, then pulses the active-low read or write strobe. While a write is in progress it drives the data bus and raises a drive-enable so the pad can turn the bus around. When the cycle ends it returns the captured read data, zero-extended to 32 bits, and pulses an acknowledge.

Each cycle has four counted phases: address setup, strobe, hold, and recovery. Their lengths come from one packed 32-bit timing word, so software can switch between slow and fast transfer modes by loading one value. For example, a slow mode uses counts 0x04, 0x1c, 0x02, 0x18 for setup, strobe, hold and recovery, and a fast mode uses 0x00, 0x06, 0x00, 0x02. The drive can also stretch the strobe through its ready line. That line passes through a synchroniser before use, and the stretch applies only when the ready-wait feature is enabled. A request made while the controller is disabled is answered at once with zero data and causes no bus activity.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high (inactive), the drive-enable is low, the acknowledge is low and the read data is zero.
- R2: The timing word is sampled when a request is accepted. Bits [7:0] hold the setup count, bits [15:8] the strobe count, bits [23:16] the hold count and bits [31:24] the recovery count.
- R3: In the setup phase, chip select is low, the register index is driven on the address output, and both strobes are high. The phase lasts setup count + 1 clocks.
- R4: In the strobe phase, the read strobe (for a read) or the write strobe (for a write) is low for strobe count + 1 clocks. The other strobe stays high, and the two strobes are never low together.
- R5: The hold phase keeps chip select low with both strobes high for hold count + 1 clocks. Recovery follows with chip select high for recovery count + 1 clocks. The acknowledge is then high for exactly one clock.
- R6: When ready-wait is enabled, the strobe stays low while the synchronised ready line is low. After ready rises, the strobe is released on the third rising clock edge, provided the strobe count has run out.
- R7: When ready-wait is disabled, a low ready line has no effect on the strobe width.
- R8: For a read, the bus data is captured on the edge that releases the read strobe. Bus changes during the hold phase do not alter it. Read data bits [31:16] are zero.
- R9: For a write, the data output carries the write data and the drive-enable is high from setup through hold. The drive-enable is low during recovery.
- R10: A request made while a cycle is in progress is ignored. The address stays unchanged, only one acknowledge is given, and no second cycle follows.
- R11: With the controller disabled, a request is acknowledged on the next clock with zero read data, and chip select never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable; when low, requests complete at once with zero data |
| rdy_wait_en | input | 1 | Enables stretching of the strobe by the drive ready line |
| timing_word | input | 32 | Packed phase counts: recovery, hold, strobe, setup (MSB to LSB) |
| req_valid | input | 1 | One-clock request pulse, accepted only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_reg | input | 4 | Device register index |
| req_wdata | input | 16 | Write data |
| dev_rdy | input | 1 | Drive ready line, asynchronous |
| dev_din | input | 16 | Data bus from the drive |
| dev_addr | output | 4 | Register index to the drive |
| dev_cs_n | output | 1 | Active-low chip select |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_dout | output | 16 | Data bus to the drive |
| dev_doe | output | 1 | Data bus drive enable |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data, upper half zero |

## Verification
A vector table runs reads and writes across five transfer-mode timing words, an all-zero word and a word with a distinct count in every byte. Because every phase is measured separately, a swapped field or a count that is off by one appears in one specific phase. Directed cases hold ready low with waiting enabled and then disabled, which separates a live wait from an ignored input. Other cases change the bus data during the hold phase to expose a late capture point, send a second request in the middle of a cycle, and send a request with the controller disabled.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    // Field slots inside the packed timing word, least significant first.
    localparam int FLD_SETUP   = 0;
    localparam int FLD_STROBE  = 1;
    localparam int FLD_HOLD    = 2;
    localparam int FLD_RECOVER = 3;
    localparam int NUM_FIELDS  = 4;

endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stg_d = async_in;
        end else begin : g_chain
            always_comb stg_d = {stg_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_out = stg_q[STAGES-1];

    AST_SYNC_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stg_q[0] == $past(async_in)) else $error("sync stage"); // R6

endmodule

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired) else $error("timer wrapped"); // R5

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int HOST_W      = 32,
    parameter int IDX_W       = 4,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctrl_en,
    input  logic                         rdy_wait_en,
    input  logic [NUM_FIELDS*CNT_W-1:0]  timing_word,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [IDX_W-1:0]             req_reg,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic                         dev_rdy,
    input  logic [DATA_W-1:0]            dev_din,
    output logic [IDX_W-1:0]             dev_addr,
    output logic                         dev_cs_n,
    output logic                         dev_rd_n,
    output logic                         dev_wr_n,
    output logic [DATA_W-1:0]            dev_dout,
    output logic                         dev_doe,
    output logic                         ack,
    output logic [HOST_W-1:0]            rdata
);
    localparam int TW_W  = NUM_FIELDS * CNT_W;
    localparam int PAD_W = HOST_W - DATA_W;

    typedef struct packed {
        phase_e             phase;
        logic               is_write;
        logic [IDX_W-1:0]   reg_idx;
        logic [DATA_W-1:0]  wdata;
        logic [TW_W-1:0]    timing;
        logic [DATA_W-1:0]  rdata;
        logic               cs_n;
        logic               rd_n;
        logic               wr_n;
        logic               doe;
        logic               ack;
    } seq_t;

    seq_t st_d, st_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rdy_s;

    function automatic logic [CNT_W-1:0] field(input logic [TW_W-1:0] tw, input int slot);
        return tw[slot*CNT_W +: CNT_W];
    endfunction

    pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_rdy),
        .sync_out (rdy_s)
    );

    pio_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (ctrl_en) begin
                        st_d.phase    = PH_SETUP;
                        st_d.is_write = req_write;
                        st_d.reg_idx  = req_reg;
                        st_d.wdata    = req_wdata;
                        st_d.timing   = timing_word;
                        tmr_load      = 1'b1;
                        tmr_val       = field(timing_word, FLD_SETUP);
                    end else begin
                        st_d.ack   = 1'b1;
                        st_d.rdata = '0;
                    end
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    st_d.phase = PH_STROBE;
                    tmr_load   = 1'b1;
                    tmr_val    = field(st_q.timing, FLD_STROBE);
                end
            end
            PH_STROBE: begin
                if (tmr_expired && (!rdy_wait_en || rdy_s)) begin
                    st_d.phase = PH_HOLD;
                    tmr_load   = 1'b1;
                    tmr_val    = field(st_q.timing, FLD_HOLD);
                    if (!st_q.is_write) st_d.rdata = dev_din;
                end
            end
            PH_HOLD: begin
                if (tmr_expired) begin
                    st_d.phase = PH_RECOVER;
                    tmr_load   = 1'b1;
                    tmr_val    = field(st_q.timing, FLD_RECOVER);
                end
            end
            PH_RECOVER: begin
                if (tmr_expired) begin
                    st_d.phase = PH_IDLE;
                    st_d.ack   = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        // Bus controls follow the phase being entered.
        st_d.cs_n = !(st_d.phase inside {PH_SETUP, PH_STROBE, PH_HOLD});
        st_d.rd_n = !(st_d.phase == PH_STROBE && !st_d.is_write);
        st_d.wr_n = !(st_d.phase == PH_STROBE &&  st_d.is_write);
        st_d.doe  =  (st_d.phase inside {PH_SETUP, PH_STROBE, PH_HOLD}) && st_d.is_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_IDLE;
            st_q.cs_n     <= 1'b1;
            st_q.rd_n     <= 1'b1;
            st_q.wr_n     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_addr = st_q.reg_idx;
    assign dev_cs_n = st_q.cs_n;
    assign dev_rd_n = st_q.rd_n;
    assign dev_wr_n = st_q.wr_n;
    assign dev_dout = st_q.wdata;
    assign dev_doe  = st_q.doe;
    assign ack      = st_q.ack;
    assign rdata    = {{PAD_W{1'b0}}, st_q.rdata};

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> !dev_cs_n) else $error("strobe without cs"); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n)) else $error("both strobes"); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack) else $error("ack too long"); // R5
    AST_RDY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STROBE && rdy_wait_en && !rdy_s) |=> st_q.phase == PH_STROBE)
        else $error("strobe released while not ready"); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_cs_n |=> (dev_cs_n || $stable(dev_addr))) else $error("address moved"); // R10
    AST_DISABLED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && req_valid && !ctrl_en) |=> (ack && dev_cs_n))
        else $error("disabled request"); // R11

endmodule

// File: tb/pio_cycle_seq_tb.sv
`timescale 1ns/1ps
module pio_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b1;
    logic        rdy_wait_en = 1'b1;
    logic [31:0] timing_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        dev_rdy = 1'b1;
    logic [15:0] dev_din = '0;
    logic [3:0]  dev_addr;
    logic        dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, ack;
    logic [15:0] dev_dout;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pio_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .rdy_wait_en(rdy_wait_en),
        .timing_word(timing_word), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .dev_rdy(dev_rdy), .dev_din(dev_din),
        .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
        .dev_dout(dev_dout), .dev_doe(dev_doe), .ack(ack), .rdata(rdata)
    );

    // {timing[31:0], write, reg[3:0], data[15:0]}
    localparam logic [52:0] VEC [7] = '{
        {32'h18021c04, 1'b0, 4'd3,  16'hA55A},
        {32'h05011c02, 1'b1, 4'd7,  16'h1234},
        {32'h01011c00, 1'b0, 4'd0,  16'hFFFF},
        {32'h07000700, 1'b1, 4'd15, 16'h8001},
        {32'h02000600, 1'b0, 4'd9,  16'h0F0F},
        {32'h00000000, 1'b0, 4'd5,  16'h7E81},
        {32'h03020100, 1'b1, 4'd12, 16'hC3C3}
    };

    int m_setup, m_strobe, m_hold, m_recov;
    bit m_strobe_bad, m_doe_bad, m_addr_bad;
    logic [31:0] m_rdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Issue one request and measure every phase until the acknowledge.
    task automatic run_cycle(input logic [31:0] tw, input bit wr, input logic [3:0] idx,
                             input logic [15:0] dat, input bit poke);
        int guard;
        int k;
        m_setup = 0; m_strobe = 0; m_hold = 0; m_recov = 0;
        m_strobe_bad = 0; m_doe_bad = 0; m_addr_bad = 0;
        @(negedge clk);
        timing_word = tw; req_write = wr; req_reg = idx; req_wdata = dat;
        dev_din = dat; req_valid = 1'b1;
        guard = 0; k = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1; req_reg = ~idx; req_write = ~wr;
            end
            k++;
            if (ack) break;
            if (!dev_rd_n || !dev_wr_n) begin
                m_strobe++;
                if (wr ? (dev_wr_n || !dev_rd_n) : (dev_rd_n || !dev_wr_n)) m_strobe_bad = 1;
            end else if (!dev_cs_n) begin
                if (m_strobe == 0) m_setup++;
                else begin
                    m_hold++;
                    if (!wr) dev_din = ~dat;
                end
            end else m_recov++;
            if (!dev_cs_n && dev_addr != idx) m_addr_bad = 1;
            if (!dev_cs_n && wr && (!dev_doe || dev_dout != dat)) m_doe_bad = 1;
            if (!dev_cs_n && !wr && dev_doe) m_doe_bad = 1;
            if (dev_cs_n && dev_doe) m_doe_bad = 1;
            guard++;
            if (guard > 3000) break;
        end
        m_rdata = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dev_cs_n && dev_rd_n && dev_wr_n && !dev_doe && !ack && rdata == 0,
            "R1 reset outputs", {dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, ack}, 5'b11100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: field order and phase lengths
        foreach (VEC[i]) begin
            logic [31:0] tw;
            bit wr;
            logic [3:0] idx;
            logic [15:0] dat;
            {tw, wr, idx, dat} = VEC[i];
            run_cycle(tw, wr, idx, dat, 1'b0);
            chk(m_setup == tw[7:0] + 1,    "R2/R3 setup length", m_setup, tw[7:0] + 1);
            chk(m_strobe == tw[15:8] + 1,  "R2/R4 strobe length", m_strobe, tw[15:8] + 1);
            chk(!m_strobe_bad,             "R4 strobe polarity", m_strobe_bad, 0);
            chk(m_hold == tw[23:16] + 1,   "R2/R5 hold length", m_hold, tw[23:16] + 1);
            chk(m_recov == tw[31:24] + 1,  "R2/R5 recovery length", m_recov, tw[31:24] + 1);
            chk(!m_addr_bad,               "R3 address", m_addr_bad, 0);
            chk(!m_doe_bad,                "R9 write data/enable", m_doe_bad, 0);
            if (!wr) chk(m_rdata == {16'h0, dat}, "R8 read capture", m_rdata, {16'h0, dat});
            @(negedge clk);
            chk(!ack, "R5 ack single pulse", ack, 0);
        end

        // R7: ready low but waiting disabled
        rdy_wait_en = 1'b0; dev_rdy = 1'b0;
        run_cycle(32'h02000600, 1'b0, 4'd2, 16'h5A5A, 1'b0);
        chk(m_strobe == 7, "R7 ready ignored", m_strobe, 7);

        // R6: ready low with waiting enabled stretches the strobe
        rdy_wait_en = 1'b1;
        @(negedge clk);
        timing_word = 32'h00000100; req_write = 1'b0; req_reg = 4'd6;
        dev_din = 16'h3C3C; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (dev_rd_n) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(!dev_rd_n, "R6 strobe held while not ready", dev_rd_n, 0);
        dev_rdy = 1'b1;
        repeat (2) @(negedge clk);
        chk(!dev_rd_n, "R6 strobe after two edges", dev_rd_n, 0);
        @(negedge clk);
        chk(dev_rd_n, "R6 strobe released on third edge", dev_rd_n, 1);
        dev_din = 16'h0000;
        while (!ack) @(negedge clk);
        chk(rdata == 32'h00003C3C, "R8 capture after wait", rdata, 32'h00003C3C);

        // R10: request in the middle of a cycle is ignored
        run_cycle(32'h07000700, 1'b1, 4'd10, 16'hBEEF, 1'b1);
        chk(!m_addr_bad && m_strobe == 8 && !m_strobe_bad, "R10 busy request ignored",
            {m_addr_bad, m_strobe[7:0]}, 8);
        begin
            bit extra;
            extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (ack || !dev_cs_n) extra = 1;
            end
            chk(!extra, "R10 no second cycle", extra, 0);
        end

        // R11: disabled controller answers at once with zero
        ctrl_en = 1'b0; dev_din = 16'hDEAD;
        @(negedge clk);
        req_write = 1'b0; req_reg = 4'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ack && rdata == 0 && dev_cs_n, "R11 disabled ack", {ack, rdata[30:0]}, 32'h80000000);
        @(negedge clk);
        chk(!ack && dev_cs_n, "R11 single ack no cycle", {ack, dev_cs_n}, 2'b01);
        ctrl_en = 1'b1;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule